// File: doc/BRIEF.md
# Wakeup External Interrupt Controller

This block watches 28 external interrupt lines, numbered 0 to 27. Each line passes through a two-stage synchroniser into the system clock domain. A programmable trigger detector then looks at the line for a low level, a high level, a falling edge, a rising edge or either edge. A detected event sets the line's bit in a pending register. Each pending bit is then gated by a mask bit and folded into one of four combined interrupt outputs. The four outputs cover fixed ranges of lines of unequal size.

Software reaches the block through a small register bus: a write strobe, a byte address, write data and combinational read data. There are two trigger configuration words, one mask word and one pending word. Pending bits are cleared by writing 1. Lines are configured in pairs: two adjacent lines always share one 4-bit trigger field.

Top module: `wake_irq_ctrl`

## Requirements
- R1: While reset is active and right after it, the mask word reads 0x0FFFFFFF (all lines masked), the pending word reads 0, both configuration words read 0 and all four outputs are low.
- R2: A change on an input line sets its pending bit at the third rising clock edge after the change, and not before.
- R3: Trigger codes are 0 for level low, 1 for level high, 2 for falling edge, 4 for rising edge and 6 for both edges. An edge mode does not react to the opposite edge.
- R4: The trigger codes 3, 5, 7 and 8 to 15 detect nothing on any line.
- R5: Line n takes its trigger from the 4-bit field at bits 4*((n/2) mod 8) of the configuration word at byte address 0x0 for n < 16, or at 0x4 for n >= 16. Lines 2k and 2k+1 therefore share one field.
- R6: A mask bit of 1 keeps its line off the outputs, while the line's pending bit still sets and reads back. A mask bit of 0 lets the pending bit through.
- R7: Writing the pending word at address 0xC clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R8: Output 0 is high when any unmasked pending line among 0 to 3 is set. Output 1 covers lines 4 to 11, output 2 covers lines 12 to 19 and output 3 covers lines 20 to 27.
- R9: In a level mode the pending bit is set again on every clock while the active level lasts. A clear written during that time has no effect: an event in the same cycle wins over a clear.
- R10: The mask word is at 0x8 and uses bits 27:0. The second configuration word at 0x4 holds fields only in bits 23:0, and its bits 31:24 read 0. Reads are combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | 28 | Raw external interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address (0x0, 0x4, 0x8, 0xC) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq_out | output | 4 | Combined interrupt outputs, one per line range |

## Verification
An input change passes two synchroniser flops and is compared with a third, delayed copy. The pending bit, and with it the output, therefore changes on the third rising edge after the stimulus. The bench drives inputs on falling edges and checks the pending word after two falling edges, expecting no change yet, and again after the third, expecting the bit set. Register writes take effect at the single rising edge under the strobe. So every pending, mask and output check after a write is sampled at the next falling edge. For level modes the bench waits three edges after the input goes inactive before it expects a clear to hold.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;

  localparam int NUM_LINES       = 28;
  localparam int TRIG_W          = 4;
  localparam int LINES_PER_FIELD = 2;
  localparam int FIELDS_PER_WORD = 8;
  localparam int NUM_OUTS        = 4;
  localparam int BUS_W           = 32;
  localparam int ADDR_W          = 4;

  typedef logic [TRIG_W-1:0] trig_t;

  localparam trig_t TRG_LVL_LO = 4'd0;
  localparam trig_t TRG_LVL_HI = 4'd1;
  localparam trig_t TRG_FALL   = 4'd2;
  localparam trig_t TRG_RISE   = 4'd4;
  localparam trig_t TRG_BOTH   = 4'd6;

  localparam logic [ADDR_W-1:0] ADR_CFG_LO = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_CFG_HI = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_MASK   = 4'h8;
  localparam logic [ADDR_W-1:0] ADR_PEND   = 4'hC;

  // First and last line served by each combined output
  function automatic int out_first(input int k);
    case (k)
      0:       return 0;
      1:       return 4;
      2:       return 12;
      default: return 20;
    endcase
  endfunction

  function automatic int out_last(input int k);
    case (k)
      0:       return 3;
      1:       return 11;
      2:       return 19;
      default: return 27;
    endcase
  endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] level_prev
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;
  logic [WIDTH-1:0] stage3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      stage3_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
      stage3_q <= stage2_q;
    end
  end

  assign level      = stage2_q;
  assign level_prev = stage3_q;

endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import wake_irq_pkg::*;
#(
  parameter int N = 28
) (
  input  logic [N-1:0]        level,
  input  logic [N-1:0]        level_prev,
  input  logic [N*TRIG_W-1:0] mode,
  output logic [N-1:0]        evt
);

  for (genvar n = 0; n < N; n++) begin : g_line
    trig_t code;
    assign code = mode[n*TRIG_W +: TRIG_W];

    always_comb begin
      case (code)
        TRG_LVL_LO: evt[n] = ~level[n];
        TRG_LVL_HI: evt[n] = level[n];
        TRG_FALL:   evt[n] = level_prev[n] & ~level[n];
        TRG_RISE:   evt[n] = ~level_prev[n] & level[n];
        TRG_BOTH:   evt[n] = level_prev[n] ^ level[n];
        default:    evt[n] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/wake_combine.sv
module wake_combine
  import wake_irq_pkg::*;
#(
  parameter int N    = 28,
  parameter int NOUT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pend,
  input  logic [N-1:0]    mask,
  output logic [NOUT-1:0] irq_out
);

  logic [N-1:0] live;
  assign live = pend & ~mask;

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    localparam int LO = out_first(k);
    localparam int HI = out_last(k);
    assign irq_out[k] = |live[HI:LO];
  end

  // R6: with every line masked no output may rise
  a_r6_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> (irq_out == '0));

endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
  import wake_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_irq,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [BUS_W-1:0]     reg_wdata,
  output logic [BUS_W-1:0]     reg_rdata,
  output logic [NUM_OUTS-1:0]  irq_out
);

  localparam int N       = NUM_LINES;
  localparam int NFIELDS = (N + LINES_PER_FIELD - 1) / LINES_PER_FIELD;
  localparam int FPW     = FIELDS_PER_WORD;

  logic [N-1:0] lvl, lvl_prev, evt;
  logic [N*TRIG_W-1:0] mode_flat;

  logic [NFIELDS-1:0][TRIG_W-1:0] cfg_q, cfg_d;
  logic [N-1:0] mask_q, mask_d;
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] clr_vec;
  logic         cfg_we, mask_we;

  wake_sync #(.WIDTH(N)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (ext_irq),
    .level      (lvl),
    .level_prev (lvl_prev)
  );

  for (genvar n = 0; n < N; n++) begin : g_mode
    assign mode_flat[n*TRIG_W +: TRIG_W] = cfg_q[n / LINES_PER_FIELD];
  end

  wake_detect #(.N(N)) u_detect (
    .level      (lvl),
    .level_prev (lvl_prev),
    .mode       (mode_flat),
    .evt        (evt)
  );

  // Next-state logic
  always_comb begin
    cfg_d   = cfg_q;
    mask_d  = mask_q;
    clr_vec = '0;
    cfg_we  = 1'b0;
    mask_we = 1'b0;
    if (reg_wr) begin
      case (reg_addr)
        ADR_CFG_LO: begin
          cfg_we = 1'b1;
          for (int f = 0; f < FPW; f++)
            if (f < NFIELDS) cfg_d[f] = reg_wdata[f*TRIG_W +: TRIG_W];
        end
        ADR_CFG_HI: begin
          cfg_we = 1'b1;
          for (int f = 0; f < FPW; f++)
            if (FPW + f < NFIELDS) cfg_d[FPW+f] = reg_wdata[f*TRIG_W +: TRIG_W];
        end
        ADR_MASK: begin
          mask_we = 1'b1;
          mask_d  = reg_wdata[N-1:0];
        end
        ADR_PEND: clr_vec = reg_wdata[N-1:0];
        default: ;
      endcase
    end
    // a fresh event wins over a clear in the same cycle
    pend_d = (pend_q & ~clr_vec) | evt;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (cfg_we)  cfg_q  <= cfg_d;
      if (mask_we) mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  // Read path
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CFG_LO:
        for (int f = 0; f < FPW; f++)
          if (f < NFIELDS) reg_rdata[f*TRIG_W +: TRIG_W] = cfg_q[f];
      ADR_CFG_HI:
        for (int f = 0; f < FPW; f++)
          if (FPW + f < NFIELDS) reg_rdata[f*TRIG_W +: TRIG_W] = cfg_q[FPW+f];
      ADR_MASK: reg_rdata[N-1:0] = mask_q;
      ADR_PEND: reg_rdata[N-1:0] = pend_q;
      default: ;
    endcase
  end

  wake_combine #(.N(N), .NOUT(NUM_OUTS)) u_combine (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend_q),
    .mask    (mask_q),
    .irq_out (irq_out)
  );

  // R7: written ones clear unless an event arrives in the same cycle
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_PEND) |=>
      ((pend_q & $past(reg_wdata[N-1:0]) & ~$past(evt)) == '0));

  // R7: a pending bit never drops without a written one
  a_r7_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0));

  // R9: every detected event leaves its pending bit set
  a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (($past(evt) & ~pend_q) == '0));

endmodule

// File: tb/wake_irq_ctrl_test.sv
module wake_irq_ctrl_test;
  import wake_irq_pkg::*;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NUM_LINES-1:0] ext_irq;
  logic                 reg_wr;
  logic [ADDR_W-1:0]    reg_addr;
  logic [BUS_W-1:0]     reg_wdata;
  logic [BUS_W-1:0]     reg_rdata;
  logic [NUM_OUTS-1:0]  irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [31:0] ALL_LINES = 32'h0FFF_FFFF;

  always #10 clk = ~clk;

  wake_irq_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_irq   (ext_irq),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_pend(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(ADR_PEND, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(ADR_CFG_LO, v); chk("R1 cfg lo", v, 32'h0);
    rd(ADR_CFG_HI, v); chk("R1 cfg hi", v, 32'h0);
    rd(ADR_MASK, v);   chk("R1 mask", v, ALL_LINES);
    rd(ADR_PEND, v);   chk("R1 pend", v, 32'h0);
    chk("R1 irq_out", {28'h0, irq_out}, 32'h0);
  endtask

  task automatic t_setup();
    wr(ADR_CFG_LO, 32'h4444_4444);
    wr(ADR_CFG_HI, 32'h0044_4444);
    wait_n(4);
    wr(ADR_PEND, ALL_LINES);
    chk_pend("R7 clear all", 32'h0);
  endtask

  task automatic t_rise();
    ext_irq[5] = 1'b1;
    wait_n(2);
    chk_pend("R2 not yet", 32'h0);
    wait_n(1);
    chk_pend("R2 R3 rise", 32'h20);
    chk("R6 masked quiet", {28'h0, irq_out}, 32'h0);
    wr(ADR_MASK, ALL_LINES & ~32'h20);
    chk("R8 line5 out1", {28'h0, irq_out}, 32'h2);
    wr(ADR_PEND, 32'h0);
    chk_pend("R7 write zero", 32'h20);
    wr(ADR_PEND, 32'h20);
    chk_pend("R7 w1c", 32'h0);
    chk("R6 out low", {28'h0, irq_out}, 32'h0);
    ext_irq[5] = 1'b0;
    wait_n(4);
    chk_pend("R3 rise ignores fall", 32'h0);
    wr(ADR_MASK, ALL_LINES);
  endtask

  task automatic t_fall_pair();
    wr(ADR_CFG_LO, 32'h4444_4442);
    ext_irq[1:0] = 2'b11;
    wait_n(4);
    chk_pend("R3 fall ignores rise", 32'h0);
    ext_irq[1:0] = 2'b00;
    wait_n(3);
    chk_pend("R5 shared fall field", 32'h3);
    wr(ADR_PEND, 32'h3);
    wr(ADR_CFG_LO, 32'h4444_4444);
  endtask

  task automatic t_both();
    wr(ADR_CFG_HI, 32'h0044_4644);
    ext_irq[20] = 1'b1;
    wait_n(3);
    chk_pend("R3 R5 both rise", 32'h0010_0000);
    wr(ADR_PEND, 32'h0010_0000);
    ext_irq[20] = 1'b0;
    wait_n(3);
    chk_pend("R3 both fall", 32'h0010_0000);
    wr(ADR_MASK, ALL_LINES & ~32'h0010_0000);
    chk("R8 line20 out3", {28'h0, irq_out}, 32'h8);
    wr(ADR_PEND, 32'h0010_0000);
    wr(ADR_MASK, ALL_LINES);
    wr(ADR_CFG_HI, 32'h0044_4444);
  endtask

  task automatic t_level();
    wr(ADR_CFG_LO, 32'h4441_4444);
    ext_irq[8] = 1'b1;
    wait_n(3);
    chk_pend("R3 level high", 32'h100);
    wr(ADR_PEND, 32'h100);
    chk_pend("R9 level resets", 32'h100);
    ext_irq[8] = 1'b0;
    wait_n(3);
    wr(ADR_PEND, 32'h100);
    chk_pend("R9 clear after inactive", 32'h0);
    wr(ADR_CFG_LO, 32'h4401_4444);
    wait_n(1);
    chk_pend("R3 R5 level low pair", 32'hC00);
    wr(ADR_CFG_LO, 32'h4444_4444);
    wr(ADR_PEND, 32'hC00);
    chk_pend("R7 level low cleared", 32'h0);
  endtask

  task automatic t_unlisted();
    logic [31:0] v;
    wr(ADR_CFG_LO, 32'h3578_F9AB);
    wr(ADR_CFG_HI, 32'hFFCD_E3F5);
    rd(ADR_CFG_HI, v);
    chk("R10 hi upper bits", v, 32'h00CD_E3F5);
    wr(ADR_MASK, 32'hFFFF_FFFF);
    rd(ADR_MASK, v);
    chk("R10 mask width", v, ALL_LINES);
    ext_irq = '1;
    wait_n(4);
    chk_pend("R4 no event up", 32'h0);
    ext_irq = '0;
    wait_n(4);
    chk_pend("R4 no event down", 32'h0);
    wr(ADR_CFG_LO, 32'h4444_4444);
    wr(ADR_CFG_HI, 32'h0044_4444);
  endtask

  task automatic t_groups();
    int lines [8] = '{0, 3, 4, 11, 12, 19, 20, 27};
    int grps  [8] = '{0, 0, 1, 1, 2, 2, 3, 3};
    wr(ADR_MASK, 32'h0);
    for (int i = 0; i < 8; i++) begin
      ext_irq[lines[i]] = 1'b1;
      wait_n(3);
      chk($sformatf("R8 line %0d", lines[i]), {28'h0, irq_out}, 32'h1 << grps[i]);
      wr(ADR_PEND, 32'h1 << lines[i]);
      ext_irq[lines[i]] = 1'b0;
      wait_n(3);
    end
    chk_pend("R8 end clean", 32'h0);
    wr(ADR_MASK, ALL_LINES);
  endtask

  initial begin
    rst_n     = 1'b0;
    ext_irq   = '0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    t_setup();
    t_rise();
    t_fall_pair();
    t_both();
    t_level();
    t_unlisted();
    t_groups();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule